// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit carries out the first group of operate microinstructions of a 12-bit accumulator machine. It takes one 12-bit instruction word, the current accumulator value and the current link bit. When the execute strobe is high and the word belongs to the group, it writes a new accumulator and link into its output registers. A word in this group has opcode 7 and a 0 in the group-select bit.

The low eight bits of the word are independent control bits, and any combination of them can appear in one word. They take effect in two fixed phases:

- **Phase one:** clear, then complement. A clear always acts before a complement, so a word that does both produces a value of all ones.
- **Phase two:** increment, then rotate. Rotates run through a 13-bit ring with the link above the accumulator MSB. One bit doubles the rotate distance.

The surrounding datapath feeds the registered result back as the next current value.

Top module: `opr1_unit`

## Requirements
- R1: While reset is asserted and after it is released, `acc_o` and `link_o` are 0 until the first executed word.
- R2: The registers keep their value when `exec_i` is low. They also keep it when the word does not have bits [11:9] = 3'b111 with bit 8 = 0.
- R3: Octal word 7000 writes `acc_i` and `link_i` to the outputs unchanged.
- R4: Bit 7 (octal 0200) clears the accumulator and bit 6 (0100) clears the link, both before any complement. So 7240 gives all ones and 7120 gives link = 1.
- R5: Bit 5 (0040) replaces the accumulator with its ones' complement, and bit 4 (0020) inverts the link.
- R6: Bit 0 (0001) adds one to the phase-one accumulator. A carry out of the MSB inverts the link, and 7041 forms the two's complement.
- R7: Bit 2 (0004) rotates the 13-bit link:accumulator ring left by one place: the link enters the accumulator LSB and the MSB enters the link. Bit 3 (0010) rotates right by one place: the LSB enters the link and the link enters the MSB.
- R8: Bit 1 (0002) makes a single-direction rotate two places. On its own it changes nothing.
- R9: Within phase two the increment is applied before the rotate.
- R10: With both rotate bits set, no rotate happens, and the result is the value after the clear, complement and increment steps.
- R11: The result of an executed word appears on the outputs one clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe, one cycle per word |
| instr_i | input | 12 | Instruction word, bit 11 is the MSB |
| acc_i | input | DATA_W | Current accumulator |
| link_i | input | 1 | Current link |
| acc_o | output | DATA_W | Registered new accumulator |
| link_o | output | 1 | Registered new link |

## Verification
The bench builds the unit with the default DATA_W of 12. This lets the bench model use the word's own octal codes directly, and lets a directed all-ones accumulator reach the carry out of the MSB. Random control bytes over random accumulator and link values exercise many mixed clear, complement, increment and rotate combinations. Directed words pin down the phase ordering, the doubled rotate and the conflicting-direction case.

// File: rtl/opr1_pkg.sv
package opr1_pkg;
  localparam int INSTR_W = 12;
  localparam logic [2:0] OPC_OPERATE = 3'b111;

  typedef struct packed {
    logic sel;
    logic clr_acc;
    logic clr_lnk;
    logic inv_acc;
    logic inv_lnk;
    logic rot_r;
    logic rot_l;
    logic rot_dbl;
    logic inc;
  } opr1_ctl_t;
endpackage

// File: rtl/opr1_decode.sv
module opr1_decode
  import opr1_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output opr1_ctl_t          ctl
);
  always_comb begin
    ctl.sel     = (instr[11:9] == OPC_OPERATE) && !instr[8];
    ctl.clr_acc = instr[7];
    ctl.clr_lnk = instr[6];
    ctl.inv_acc = instr[5];
    ctl.inv_lnk = instr[4];
    ctl.rot_r   = instr[3];
    ctl.rot_l   = instr[2];
    ctl.rot_dbl = instr[1];
    ctl.inc     = instr[0];
  end
endmodule

// File: rtl/opr1_phase1.sv
module opr1_phase1
  import opr1_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  opr1_ctl_t         ctl,
  input  logic [DATA_W-1:0] acc,
  input  logic              lnk,
  output logic [DATA_W-1:0] acc_out,
  output logic              lnk_out
);
  logic [DATA_W-1:0] acc_clr;
  logic              lnk_clr;

  always_comb begin
    acc_clr = ctl.clr_acc ? '0 : acc;
    lnk_clr = ctl.clr_lnk ? 1'b0 : lnk;
    acc_out = ctl.inv_acc ? ~acc_clr : acc_clr;
    lnk_out = ctl.inv_lnk ? ~lnk_clr : lnk_clr;
  end
endmodule

// File: rtl/opr1_phase2.sv
module opr1_phase2
  import opr1_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  opr1_ctl_t         ctl,
  input  logic [DATA_W-1:0] acc,
  input  logic              lnk,
  output logic [DATA_W-1:0] acc_out,
  output logic              lnk_out
);
  localparam int RING_W = DATA_W + 1;
  localparam int STEPS  = 2;

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] acc_inc;
  logic              lnk_inc;
  logic              do_rot;
  logic              go_left;
  logic [STEPS:0][RING_W-1:0] ring;

  always_comb begin
    sum     = {1'b0, acc} + {{DATA_W{1'b0}}, ctl.inc};
    acc_inc = sum[DATA_W-1:0];
    lnk_inc = lnk ^ sum[DATA_W];
    do_rot  = ctl.rot_l ^ ctl.rot_r;
    go_left = ctl.rot_l;
  end

  assign ring[0] = {lnk_inc, acc_inc};

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    logic en;
    assign en = (s == 0) ? do_rot : (do_rot && ctl.rot_dbl);
    assign ring[s+1] = !en ? ring[s] :
                       go_left ? {ring[s][RING_W-2:0], ring[s][RING_W-1]}
                               : {ring[s][0], ring[s][RING_W-1:1]};
  end

  assign lnk_out = ring[STEPS][RING_W-1];
  assign acc_out = ring[STEPS][DATA_W-1:0];
endmodule

// File: rtl/opr1_unit.sv
module opr1_unit
  import opr1_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic               link_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic               link_o
);
  opr1_ctl_t         ctl;
  logic [DATA_W-1:0] acc_p1, acc_p2, acc_d, acc_q;
  logic              lnk_p1, lnk_p2, lnk_d, lnk_q;
  logic              load_en;

  opr1_decode u_dec (.instr(instr_i), .ctl(ctl));

  opr1_phase1 #(.DATA_W(DATA_W)) u_ph1 (
    .ctl(ctl), .acc(acc_i), .lnk(link_i), .acc_out(acc_p1), .lnk_out(lnk_p1)
  );

  opr1_phase2 #(.DATA_W(DATA_W)) u_ph2 (
    .ctl(ctl), .acc(acc_p1), .lnk(lnk_p1), .acc_out(acc_p2), .lnk_out(lnk_p2)
  );

  always_comb begin
    load_en = exec_i && ctl.sel;
    acc_d   = load_en ? acc_p2 : acc_q;
    lnk_d   = load_en ? lnk_p2 : lnk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      lnk_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      lnk_q <= lnk_d;
    end
  end

  assign acc_o  = acc_q;
  assign link_o = lnk_q;

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_i && instr_i[11:8] == 4'b1110) |=> ($stable(acc_o) && $stable(link_o)));

  a_r4_clear_then_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 12'o7240) |=> (acc_o == {DATA_W{1'b1}}));

  a_r5_link_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 12'o7020) |=> (link_o == !$past(link_i)));

  a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 12'o7001) |=> (acc_o == DATA_W'($past(acc_i) + 1'b1)));

  a_r7_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 12'o7004) |=> ({link_o, acc_o} == {$past(acc_i), $past(link_i)}));

  a_r10_both_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 12'o7014) |=> ({link_o, acc_o} == {$past(link_i), $past(acc_i)}));
endmodule

// File: tb/opr1_unit_tb.sv
module opr1_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_i;
  logic [11:0] instr_i;
  logic [11:0] acc_i;
  logic        link_i;
  logic [11:0] acc_o;
  logic        link_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [11:0] cur_acc;
  logic        cur_lnk;

  always #5 clk = ~clk;

  opr1_unit #(.DATA_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i),
    .acc_i(acc_i), .link_i(link_i), .acc_o(acc_o), .link_o(link_o)
  );

  function automatic logic [12:0] ref_model(input logic [11:0] w, input logic [11:0] a, input logic l);
    logic [12:0] r;
    logic [12:0] s;
    if (w[7]) a = '0;            // R4 clears first
    if (w[6]) l = 1'b0;
    if (w[5]) a = ~a;            // R5
    if (w[4]) l = ~l;
    if (w[0]) begin              // R6, R9 increment before rotate
      s = {1'b0, a} + 13'd1;
      a = s[11:0];
      if (s[12]) l = ~l;
    end
    r = {l, a};
    if (w[2] != w[3]) begin      // R10 both directions: none
      for (int k = 0; k < (w[1] ? 2 : 1); k++) begin  // R8
        if (w[2]) r = {r[11:0], r[12]};                // R7 left
        else      r = {r[0], r[12:1]};                 // R7 right
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [12:0] exp);
    n_chk++;
    if ({link_o, acc_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: got L=%0b AC=%o, expected L=%0b AC=%o",
               req, link_o, acc_o, exp[12], exp[11:0]);
    end
  endtask

  task automatic run(input string req, input logic ex, input logic [11:0] w,
                     input logic [11:0] a, input logic l);
    logic [12:0] exp;
    @(negedge clk);
    exec_i = ex; instr_i = w; acc_i = a; link_i = l;
    if (ex && w[11:8] == 4'b1110) exp = ref_model(w, a, l);
    else exp = {cur_lnk, cur_acc};
    @(negedge clk);
    exec_i = 1'b0;
    check(req, exp);             // R11 result one edge after strobe
    cur_acc = exp[11:0]; cur_lnk = exp[12];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    logic [11:0] w;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 1'b0; exec_i = 1'b0; instr_i = '0; acc_i = '0; link_i = 1'b0;
    cur_acc = '0; cur_lnk = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 13'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 13'h0);

    run("R3 no-op", 1'b1, 12'o7000, 12'o1234, 1'b1);
    run("R2 strobe low", 1'b0, 12'o7200, 12'o5555, 1'b0);
    run("R2 group2 word", 1'b1, 12'o7600, 12'o0000, 1'b0);
    run("R2 other opcode", 1'b1, 12'o1240, 12'o0007, 1'b0);
    run("R4 7240 all ones", 1'b1, 12'o7240, 12'o0123, 1'b0);
    run("R4 7120 link set", 1'b1, 12'o7120, 12'o0123, 1'b0);
    run("R4 clear both", 1'b1, 12'o7300, 12'o7777, 1'b1);
    run("R5 invert acc", 1'b1, 12'o7040, 12'o1234, 1'b0);
    run("R5 invert link", 1'b1, 12'o7020, 12'o1234, 1'b0);
    run("R6 7041 negate", 1'b1, 12'o7041, 12'o0005, 1'b0);
    run("R6 carry inverts link", 1'b1, 12'o7001, 12'o7777, 1'b0);
    run("R7 link to lsb 7204", 1'b1, 12'o7204, 12'o4321, 1'b1);
    run("R7 rotate right", 1'b1, 12'o7010, 12'o0001, 1'b0);
    run("R7 shift left 7104", 1'b1, 12'o7104, 12'o0003, 1'b1);
    run("R7 shift right 7110", 1'b1, 12'o7110, 12'o0006, 1'b1);
    run("R8 rotate two left", 1'b1, 12'o7006, 12'o4000, 1'b0);
    run("R8 rotate two right", 1'b1, 12'o7012, 12'o0003, 1'b0);
    run("R8 double alone", 1'b1, 12'o7002, 12'o2345, 1'b1);
    run("R9 inc before rotate", 1'b1, 12'o7005, 12'o7777, 1'b0);
    run("R10 both directions", 1'b1, 12'o7014, 12'o1357, 1'b1);
    run("R10 both dirs with inc", 1'b1, 12'o7017, 12'o0777, 1'b0);

    for (int i = 0; i < 400; i++) begin
      w = {4'b1110, 8'($urandom)};
      run("R6 R7 random mix", 1'b1, w, 12'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 60; i++) begin
      w = 12'($urandom);
      run("R2 random word", 1'($urandom), w, 12'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule